// File: doc/BRIEF.md
# Atomic Pair and Reservation Guard

This block sits on the request path between a core and its data cache. Each cycle it may accept one request, given as a kind code and a cache-line address. It turns the kind into the command class the cache expects and forwards the request. While doing so it enforces two sets of rules for atomic traffic.

The first set covers read-modify-write pairs. The block counts RMW reads that have no matching RMW write yet, and it counts the RMW writes that answer them. A plain access that arrives after unmatched reads, but before any write, abandons the pending sequence: the block pulses an atomics-reset strobe and clears both counts. Any sequence that breaks the ordering raises a protocol-error flag. That flag stays set until reset and blocks no traffic.

The second set covers load-linked/store-conditional. When a locked read completes, the block installs a single reservation that holds the line and the owning core. A later locked write passes only if that reservation matches this core and this line. A passing write consumes the reservation. A failing write returns a distinct status and is not forwarded. The block also keeps a mark for one line: completion of an RMW read sets it and completion of an RMW write clears it.

Top module: `rmw_llsc_guard`

## Requirements
- R1: A locked-read completion installs the reservation with the line and core it carries. Only one reservation exists, so a later completion replaces the earlier one.
- R2: A locked write (kind 6) whose line matches the reservation, and whose reservation belongs to parameter CORE_ID, returns sc_status 2'b01 and is forwarded. The reservation is then cleared, so a repeat locked write to the same line fails.
- R3: A locked write fails when no reservation exists, when the line differs, or when the owner differs. A failure returns sc_status 2'b11 and leaves issue_valid low.
- R4: An RMW read (kind 3) that arrives with no RMW writes counted increments the read count and is forwarded as class 3.
- R5: An RMW write (kind 4) that arrives with reads counted and fewer writes than reads increments the write count. When the two counts become equal, both return to zero.
- R6: A plain access (load 0, store 1, fetch 2) that arrives with reads counted and no writes counted does three things: it raises reset_atomics for exactly one cycle, it clears both counts, and it is still forwarded.
- R7: A plain access that arrives while writes are counted sets proto_err. The flag stays set until reset, and the request is still forwarded.
- R8: Three RMW cases are illegal: an RMW read while writes are counted, an RMW write while no reads are counted, and an RMW read when the read count is full. Each illegal case sets proto_err, leaves the counts unchanged and still forwards the request.
- R9: The command classes are: load to 0, store to 1, instruction fetch to 2, and locked read, locked write, RMW read and RMW write to 3. Kind 7 is never forwarded and has no effect.
- R10: An RMW-read completion sets mark_valid with mark_line. An RMW-write completion clears the mark only when its line equals mark_line.
- R11: After reset, all outputs are low, both counts are zero, and neither a reservation nor a mark is held.
- R12: Outputs are registered. A request shows on issue_valid, issue_cmd, issue_line and sc_status in the cycle after it is presented. In any cycle after a cycle with no request, issue_valid is low and sc_status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind code (see R9) |
| req_line | input | LINE_W | Cache-line address of the request |
| lrd_cpl_valid | input | 1 | Locked-read completion |
| lrd_cpl_line | input | LINE_W | Line of the completed locked read |
| lrd_cpl_core | input | CORE_W | Core identity that owns the completed locked read |
| rmw_cpl_valid | input | 1 | RMW completion |
| rmw_cpl_is_wr | input | 1 | 1 for RMW-write completion, 0 for RMW-read completion |
| rmw_cpl_line | input | LINE_W | Line of the RMW completion |
| issue_valid | output | 1 | Forwarded request valid |
| issue_cmd | output | 2 | Cache command class |
| issue_line | output | LINE_W | Forwarded line address |
| sc_status | output | 2 | Locked-write result: 00 none, 01 pass, 11 fail |
| reset_atomics | output | 1 | One-cycle strobe that abandons a pending RMW sequence |
| proto_err | output | 1 | Sticky ordering-violation flag |
| mark_valid | output | 1 | Atomic mark held |
| mark_line | output | LINE_W | Line carrying the atomic mark |

## Verification
The hardest state to reach is a saturated read count, because the bench cannot see the counts directly. The bench reduces CNT_W to 2 and sends three RMW reads, then a fourth, and observes proto_err rise only on the fourth. The same indirect approach covers the zero-return on equal counts: the bench closes a balanced pair and then checks that a plain access raises neither reset_atomics nor proto_err. For the reservation, completions for another core and a newer line are interleaved with locked writes, which separates the owner check, the line check and replacement.

// File: rtl/rmw_llsc_pkg.sv
package rmw_llsc_pkg;

   typedef enum logic [2:0] {
      RQ_LOAD    = 3'd0,
      RQ_STORE   = 3'd1,
      RQ_IFETCH  = 3'd2,
      RQ_RMW_RD  = 3'd3,
      RQ_RMW_WR  = 3'd4,
      RQ_LOCK_RD = 3'd5,
      RQ_LOCK_WR = 3'd6,
      RQ_RSVD    = 3'd7
   } req_kind_e;

   typedef enum logic [1:0] {
      CMD_LOAD   = 2'd0,
      CMD_STORE  = 2'd1,
      CMD_IFETCH = 2'd2,
      CMD_ATOMIC = 2'd3
   } cmd_class_e;

   localparam logic [1:0] SC_NONE = 2'b00;
   localparam logic [1:0] SC_PASS = 2'b01;
   localparam logic [1:0] SC_FAIL = 2'b11;

   function automatic logic kind_is_plain(input req_kind_e k);
      return (k == RQ_LOAD) || (k == RQ_STORE) || (k == RQ_IFETCH);
   endfunction

endpackage

// File: rtl/rmw_cmd_map.sv
module rmw_cmd_map
   import rmw_llsc_pkg::*;
(
   input  req_kind_e  kind,
   output cmd_class_e cmd,
   output logic       known
);
   always_comb begin
      known = 1'b1;
      unique case (kind)
         RQ_LOAD:   cmd = CMD_LOAD;
         RQ_STORE:  cmd = CMD_STORE;
         RQ_IFETCH: cmd = CMD_IFETCH;
         RQ_RMW_RD, RQ_RMW_WR, RQ_LOCK_RD, RQ_LOCK_WR: cmd = CMD_ATOMIC;
         default: begin
            cmd   = CMD_LOAD;
            known = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/rmw_pair_counter.sv
module rmw_pair_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_rmw_rd,
   input  logic             ev_rmw_wr,
   input  logic             ev_plain,
   output logic             clr_pulse,
   output logic             order_err,
   output logic [CNT_W-1:0] rd_cnt,
   output logic [CNT_W-1:0] wr_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("rmw_pair_counter: CNT_W must lie in 1..16");
      end
   endgenerate

   logic             rd_ok, wr_ok, plain_bad;
   logic [CNT_W-1:0] wr_inc;

   assign wr_inc    = wr_cnt + 1'b1;
   assign rd_ok     = (wr_cnt == CNT_ZERO) && (rd_cnt != CNT_MAX);
   assign wr_ok     = (rd_cnt != CNT_ZERO) && (wr_cnt < rd_cnt);
   assign clr_pulse = ev_plain && (rd_cnt != CNT_ZERO) && (wr_cnt == CNT_ZERO);
   assign plain_bad = ev_plain && (wr_cnt != CNT_ZERO);
   assign order_err = (ev_rmw_rd && !rd_ok) || (ev_rmw_wr && !wr_ok) || plain_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt <= CNT_ZERO;
         wr_cnt <= CNT_ZERO;
      end else if (clr_pulse) begin
         rd_cnt <= CNT_ZERO;
         wr_cnt <= CNT_ZERO;
      end else if (ev_rmw_rd && rd_ok) begin
         rd_cnt <= rd_cnt + 1'b1;
      end else if (ev_rmw_wr && wr_ok) begin
         if (wr_inc == rd_cnt) begin
            rd_cnt <= CNT_ZERO;
            wr_cnt <= CNT_ZERO;
         end else begin
            wr_cnt <= wr_inc;
         end
      end
   end
endmodule

// File: rtl/llsc_reservation.sv
module llsc_reservation #(
   parameter int LINE_W      = 26,
   parameter int CORE_W      = 3,
   parameter int CORE_ID     = 0,
   parameter bit OWNER_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid,
   input  logic [LINE_W-1:0] set_line,
   input  logic [CORE_W-1:0] set_core,
   input  logic              chk_valid,
   input  logic [LINE_W-1:0] chk_line,
   output logic              chk_hit,
   output logic              res_valid
);
   localparam logic [CORE_W-1:0] OWN_ID = CORE_W'(CORE_ID);

   generate
      if (CORE_ID < 0 || CORE_ID >= (1 << CORE_W)) begin : g_bad_core
         $error("llsc_reservation: CORE_ID does not fit CORE_W");
      end
   endgenerate

   logic [LINE_W-1:0] res_line;
   logic [CORE_W-1:0] res_core;
   logic              owner_ok;

   generate
      if (OWNER_CHECK) begin : g_owner
         assign owner_ok = (res_core == OWN_ID);
      end else begin : g_no_owner
         assign owner_ok = 1'b1;
      end
   endgenerate

   assign chk_hit = res_valid && owner_ok && (res_line == chk_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_line  <= '0;
         res_core  <= '0;
      end else if (set_valid) begin
         res_valid <= 1'b1;
         res_line  <= set_line;
         res_core  <= set_core;
      end else if (chk_valid && chk_hit) begin
         res_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rmw_llsc_guard.sv
module rmw_llsc_guard
   import rmw_llsc_pkg::*;
#(
   parameter int LINE_W      = 26,
   parameter int CORE_W      = 3,
   parameter int CORE_ID     = 0,
   parameter int CNT_W       = 4,
   parameter bit OWNER_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [LINE_W-1:0] req_line,
   input  logic              lrd_cpl_valid,
   input  logic [LINE_W-1:0] lrd_cpl_line,
   input  logic [CORE_W-1:0] lrd_cpl_core,
   input  logic              rmw_cpl_valid,
   input  logic              rmw_cpl_is_wr,
   input  logic [LINE_W-1:0] rmw_cpl_line,
   output logic              issue_valid,
   output logic [1:0]        issue_cmd,
   output logic [LINE_W-1:0] issue_line,
   output logic [1:0]        sc_status,
   output logic              reset_atomics,
   output logic              proto_err,
   output logic              mark_valid,
   output logic [LINE_W-1:0] mark_line
);
   generate
      if (LINE_W < 1) begin : g_bad_line_w
         $error("rmw_llsc_guard: LINE_W must be positive");
      end
      if (CORE_W < 1) begin : g_bad_core_w
         $error("rmw_llsc_guard: CORE_W must be positive");
      end
   endgenerate

   req_kind_e  kind;
   cmd_class_e cmd;
   logic       kind_known, is_plain, is_lock_wr;
   logic       cnt_clr, cnt_err, res_hit, res_held;
   logic       fwd;
   logic [1:0] sc_next;
   logic [CNT_W-1:0] cnt_rd, cnt_wr;

   assign kind       = req_kind_e'(req_kind);
   assign is_plain   = req_valid && kind_is_plain(kind);
   assign is_lock_wr = req_valid && (kind == RQ_LOCK_WR);

   rmw_cmd_map u_map (
      .kind  (kind),
      .cmd   (cmd),
      .known (kind_known)
   );

   rmw_pair_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_rmw_rd (req_valid && (kind == RQ_RMW_RD)),
      .ev_rmw_wr (req_valid && (kind == RQ_RMW_WR)),
      .ev_plain  (is_plain),
      .clr_pulse (cnt_clr),
      .order_err (cnt_err),
      .rd_cnt    (cnt_rd),
      .wr_cnt    (cnt_wr)
   );

   llsc_reservation #(
      .LINE_W      (LINE_W),
      .CORE_W      (CORE_W),
      .CORE_ID     (CORE_ID),
      .OWNER_CHECK (OWNER_CHECK)
   ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_valid (lrd_cpl_valid),
      .set_line  (lrd_cpl_line),
      .set_core  (lrd_cpl_core),
      .chk_valid (is_lock_wr),
      .chk_line  (req_line),
      .chk_hit   (res_hit),
      .res_valid (res_held)
   );

   assign fwd     = req_valid && kind_known && !(is_lock_wr && !res_hit);
   assign sc_next = !is_lock_wr ? SC_NONE : (res_hit ? SC_PASS : SC_FAIL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid   <= 1'b0;
         issue_cmd     <= '0;
         issue_line    <= '0;
         sc_status     <= SC_NONE;
         reset_atomics <= 1'b0;
         proto_err     <= 1'b0;
      end else begin
         issue_valid   <= fwd;
         issue_cmd     <= fwd ? cmd : 2'b00;
         issue_line    <= fwd ? req_line : '0;
         sc_status     <= sc_next;
         reset_atomics <= cnt_clr;
         proto_err     <= proto_err || cnt_err;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark_valid <= 1'b0;
         mark_line  <= '0;
      end else if (rmw_cpl_valid && !rmw_cpl_is_wr) begin
         mark_valid <= 1'b1;
         mark_line  <= rmw_cpl_line;
      end else if (rmw_cpl_valid && rmw_cpl_is_wr && (rmw_cpl_line == mark_line)) begin
         mark_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rmw_llsc_guard_chk.sv
module rmw_llsc_guard_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             issue_valid,
   input logic [1:0]       issue_cmd,
   input logic [1:0]       sc_status,
   input logic             reset_atomics,
   input logic             proto_err,
   input logic [CNT_W-1:0] rd_cnt,
   input logic [CNT_W-1:0] wr_cnt
);
   p_fail_blocks_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_status == 2'b11) |-> !issue_valid);

   p_pass_forwards_atomic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_status == 2'b01) |-> (issue_valid && issue_cmd == 2'b11));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_atomics |=> !reset_atomics);

   p_strobe_counts_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_atomics |-> (rd_cnt == '0 && wr_cnt == '0));

   p_writes_below_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt != '0) |-> (wr_cnt < rd_cnt));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!issue_valid && sc_status == 2'b00));
endmodule

bind rmw_llsc_guard rmw_llsc_guard_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .issue_valid   (issue_valid),
   .issue_cmd     (issue_cmd),
   .sc_status     (sc_status),
   .reset_atomics (reset_atomics),
   .proto_err     (proto_err),
   .rd_cnt        (cnt_rd),
   .wr_cnt        (cnt_wr)
);

// File: tb/rmw_llsc_guard_bench.sv
module rmw_llsc_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 8;
   localparam int CW = 2;
   localparam int MY_CORE = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [2:0]    req_kind;
   logic [LW-1:0] req_line;
   logic          lrd_cpl_valid;
   logic [LW-1:0] lrd_cpl_line;
   logic [CW-1:0] lrd_cpl_core;
   logic          rmw_cpl_valid, rmw_cpl_is_wr;
   logic [LW-1:0] rmw_cpl_line;
   logic          issue_valid, reset_atomics, proto_err, mark_valid;
   logic [1:0]    issue_cmd, sc_status;
   logic [LW-1:0] issue_line, mark_line;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rmw_llsc_guard #(.LINE_W(LW), .CORE_W(CW), .CORE_ID(MY_CORE), .CNT_W(2)) u_rmw_llsc_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
      .lrd_cpl_valid(lrd_cpl_valid), .lrd_cpl_line(lrd_cpl_line), .lrd_cpl_core(lrd_cpl_core),
      .rmw_cpl_valid(rmw_cpl_valid), .rmw_cpl_is_wr(rmw_cpl_is_wr), .rmw_cpl_line(rmw_cpl_line),
      .issue_valid(issue_valid), .issue_cmd(issue_cmd), .issue_line(issue_line),
      .sc_status(sc_status), .reset_atomics(reset_atomics), .proto_err(proto_err),
      .mark_valid(mark_valid), .mark_line(mark_line));

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_line = '0;
      lrd_cpl_valid = 1'b0; lrd_cpl_line = '0; lrd_cpl_core = '0;
      rmw_cpl_valid = 1'b0; rmw_cpl_is_wr = 1'b0; rmw_cpl_line = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // presents one request at a falling edge, samples one cycle later
   task automatic send(input int kind, input int line);
      req_valid = 1'b1; req_kind = 3'(kind); req_line = LW'(line);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic lock_cpl(input int line, input int core);
      lrd_cpl_valid = 1'b1; lrd_cpl_line = LW'(line); lrd_cpl_core = CW'(core);
      @(negedge clk);
      lrd_cpl_valid = 1'b0;
   endtask

   task automatic rmw_cpl(input bit is_wr, input int line);
      rmw_cpl_valid = 1'b1; rmw_cpl_is_wr = is_wr; rmw_cpl_line = LW'(line);
      @(negedge clk);
      rmw_cpl_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R11 issue_valid", issue_valid, 0);
      chk("R11 sc_status", sc_status, 0);
      chk("R11 reset_atomics", reset_atomics, 0);
      chk("R11 proto_err", proto_err, 0);
      chk("R11 mark_valid", mark_valid, 0);
      send(6, 1);
      chk("R11 no reservation after reset", sc_status, 3);
   endtask

   task automatic t_cmd_map();
      do_reset();
      send(0, 17); chk("R9 load class", issue_cmd, 0); chk("R12 load line", issue_line, 17);
      chk("R12 load issued", issue_valid, 1);
      @(negedge clk); chk("R12 idle no issue", issue_valid, 0);
      send(1, 18); chk("R9 store class", issue_cmd, 1);
      send(2, 19); chk("R9 fetch class", issue_cmd, 2);
      send(5, 20); chk("R9 locked read class", issue_cmd, 3);
      send(7, 21); chk("R9 reserved not issued", issue_valid, 0);
      chk("R9 reserved no error", proto_err, 0);
      send(3, 22); chk("R4 rmw read class", issue_cmd, 3); chk("R4 rmw read issued", issue_valid, 1);
      send(4, 22); chk("R9 rmw write class", issue_cmd, 3);
      chk("R9 legal pair no error", proto_err, 0);
   endtask

   task automatic t_llsc();
      do_reset();
      send(6, 5); chk("R3 no reservation fails", sc_status, 3); chk("R3 fail not issued", issue_valid, 0);
      lock_cpl(5, MY_CORE);
      send(6, 6); chk("R3 other line fails", sc_status, 3);
      send(6, 5); chk("R2 matching passes", sc_status, 1); chk("R2 pass issued", issue_valid, 1);
      chk("R2 pass class atomic", issue_cmd, 3);
      send(6, 5); chk("R2 reservation consumed", sc_status, 3);
      lock_cpl(9, 1);
      send(6, 9); chk("R3 foreign owner fails", sc_status, 3);
      lock_cpl(9, MY_CORE);
      lock_cpl(10, MY_CORE);
      send(6, 9); chk("R1 older reservation replaced", sc_status, 3);
      send(6, 10); chk("R1 newer reservation passes", sc_status, 1);
   endtask

   task automatic t_abandon();
      do_reset();
      send(3, 1); send(3, 2);
      send(0, 3); chk("R6 strobe on abandon", reset_atomics, 1); chk("R6 plain still issued", issue_valid, 1);
      chk("R6 no error", proto_err, 0);
      send(1, 4); chk("R6 counts cleared, no second strobe", reset_atomics, 0);
      send(4, 4); chk("R8 write after clear errs", proto_err, 1);
      chk("R8 illegal write still issued", issue_valid, 1);
   endtask

   task automatic t_balanced();
      do_reset();
      send(3, 1); send(3, 1); send(4, 1); send(4, 1);
      send(1, 2); chk("R5 balanced closes, no strobe", reset_atomics, 0);
      chk("R5 balanced no error", proto_err, 0);
      send(3, 1); send(3, 1); send(4, 1);
      send(0, 2); chk("R7 plain with writes pending errs", proto_err, 1);
      chk("R7 plain still issued", issue_valid, 1); chk("R7 no strobe", reset_atomics, 0);
      send(2, 2); chk("R7 error sticky", proto_err, 1);
      do_reset(); chk("R7 reset clears error", proto_err, 0);
   endtask

   task automatic t_order();
      do_reset();
      send(3, 1); send(3, 1); send(4, 1);
      send(3, 1); chk("R8 read with writes pending errs", proto_err, 1);
      do_reset();
      send(3, 1); send(3, 1); send(3, 1); chk("R4 three reads fit", proto_err, 0);
      send(3, 1); chk("R8 saturated read errs", proto_err, 1);
      send(0, 1); chk("R8 saturated count kept, strobe", reset_atomics, 1);
   endtask

   task automatic t_mark();
      do_reset();
      rmw_cpl(1'b0, 7); chk("R10 mark set", mark_valid, 1); chk("R10 mark line", mark_line, 7);
      rmw_cpl(1'b1, 8); chk("R10 other line keeps mark", mark_valid, 1);
      rmw_cpl(1'b1, 7); chk("R10 mark cleared", mark_valid, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_cmd_map();
      t_llsc();
      t_abandon();
      t_balanced();
      t_order();
      t_mark();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule